// File: doc/BRIEF.md
# DMA Software Request Handshake Registers

This block keeps the software-driven transfer requests of a multi-channel DMA controller. Each channel has a source-side and a destination-side pair of request flags: a single flag and a burst flag. Software sets these flags through a small register port. A channel with its single flag set raises a request toward its channel engine. The request type is burst only when both flags are set, and the two flags may be written in either order. The engine accepts the request with an acknowledge. At that moment the type is frozen until the engine signals done.

On done, the block clears both flags of that channel and side. It also records the event in a sticky per-channel status bit. Each side has one interrupt line, which serves both single and burst completions. The line is the OR over channels of status AND enable AND NOT mask. Software can either poll the two flags, which both read 0 once the work is finished, or wait for the interrupt.

Address map (4-bit address; bit 3 selects the side, 0 = source, 1 = destination; bits 2:0 select the register): 0 single flags (write-1-to-set), 1 burst flags (write-1-to-set), 2 completion status (write-1-to-clear), 3 interrupt enable (plain write), 4 interrupt mask (plain write, 1 = masked). Other offsets read 0 and ignore writes.

Top module: `dma_swreq_regs`

## Requirements
- R1: A write to offset 0 or 1 of a side sets each flag whose data bit is 1. Data bits of 0 leave the flag unchanged, and the other side is not affected. Offsets 3 and 4 store the written value, and every register reads back at its offset.
- R2: A channel's request output is 1 exactly when its single flag is set and no transaction of that channel is in flight. A burst flag alone raises no request. A request drops in the cycle after the engine acknowledges it.
- R3: The type output of a requesting channel is 1 (burst) when both flags are set, whichever was written first. It is 0 (single) when only the single flag is set. An idle channel without a request shows type 0.
- R4: The type is captured at acknowledge and held until done. A burst flag written during a single transaction does not change the type.
- R5: Done for an in-flight channel clears both its single and burst flags, so a burst flag written during a single transaction is never serviced, and both flags read 0.
- R6: Done for an in-flight channel sets its sticky status bit. Writing 1 to offset 2 clears status bits, and a done in the same cycle as a clearing write wins.
- R7: A side's interrupt equals the OR over channels of status AND enable AND NOT mask. The same line serves single and burst completions.
- R8: After reset all flags, status, enable and mask bits are 0, and no request or interrupt is active.
- R9: A done pulse on a channel with no transaction in flight has no effect on its status.
- R10: Source and destination sides work independently, each with its own acknowledge, done, status and interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | NCH | Write data, one bit per channel |
| rd_addr | input | 4 | Read address |
| rd_data | output | NCH | Read data (combinational) |
| src_req | output | NCH | Source-side request per channel |
| src_burst | output | NCH | Source-side type per channel, 1 = burst |
| src_ack | input | NCH | Source engine accepts request |
| src_done | input | NCH | Source engine completion pulse |
| src_irq | output | 1 | Source-side transaction-complete interrupt |
| dst_req | output | NCH | Destination-side request per channel |
| dst_burst | output | NCH | Destination-side type per channel, 1 = burst |
| dst_ack | input | NCH | Destination engine accepts request |
| dst_done | input | NCH | Destination engine completion pulse |
| dst_irq | output | 1 | Destination-side transaction-complete interrupt |

## Verification
The bench builds the block with the default of eight channels. With eight channels, a byte-wide data word covers every flag, including the top channel bit 7, which is used for the stray-done case. Channels 0, 2 and 3 carry the single-then-late-burst, burst-then-single and done-versus-clear collision cases, so they do not disturb each other. One destination channel runs next to idle source channels to show that the two sides stay separate.

// File: rtl/dma_swreq_regs.sv
module dma_swreq_regs #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [3:0]     wr_addr,
  input  logic [NCH-1:0] wr_data,
  input  logic [3:0]     rd_addr,
  output logic [NCH-1:0] rd_data,
  output logic [NCH-1:0] src_req,
  output logic [NCH-1:0] src_burst,
  input  logic [NCH-1:0] src_ack,
  input  logic [NCH-1:0] src_done,
  output logic           src_irq,
  output logic [NCH-1:0] dst_req,
  output logic [NCH-1:0] dst_burst,
  input  logic [NCH-1:0] dst_ack,
  input  logic [NCH-1:0] dst_done,
  output logic           dst_irq
);
  localparam logic [2:0] K_SGL = 3'd0;
  localparam logic [2:0] K_BST = 3'd1;
  localparam logic [2:0] K_STA = 3'd2;
  localparam logic [2:0] K_IEN = 3'd3;
  localparam logic [2:0] K_MSK = 3'd4;

  logic [1:0][NCH-1:0] req_w, typ_w, ack_w, done_w, rdv;
  logic [1:0]          irq_w;

  assign ack_w  = {dst_ack, src_ack};
  assign done_w = {dst_done, src_done};

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [NCH-1:0] sgl, bst, busy, typ, stat, ien, imsk, acc, fin;
    logic hit;

    assign hit = wr_en && (wr_addr[3] == 1'(s));
    assign acc = ack_w[s] & req_w[s];
    assign fin = done_w[s] & busy;
    assign req_w[s] = sgl & ~busy;
    assign typ_w[s] = (busy & typ) | (~busy & sgl & bst);
    assign irq_w[s] = |(stat & ien & ~imsk);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sgl  <= '0;
        bst  <= '0;
        busy <= '0;
        typ  <= '0;
        stat <= '0;
        ien  <= '0;
        imsk <= '0;
      end else begin
        sgl  <= (sgl & ~fin) | ((hit && wr_addr[2:0] == K_SGL) ? wr_data : '0);
        bst  <= (bst & ~fin) | ((hit && wr_addr[2:0] == K_BST) ? wr_data : '0);
        busy <= (busy & ~fin) | acc;
        typ  <= (typ & ~acc) | (acc & bst);
        stat <= (stat & ~((hit && wr_addr[2:0] == K_STA) ? wr_data : '0)) | fin;
        if (hit && wr_addr[2:0] == K_IEN) ien  <= wr_data;
        if (hit && wr_addr[2:0] == K_MSK) imsk <= wr_data;
      end
    end

    always_comb begin
      case (rd_addr[2:0])
        K_SGL:   rdv[s] = sgl;
        K_BST:   rdv[s] = bst;
        K_STA:   rdv[s] = stat;
        K_IEN:   rdv[s] = ien;
        K_MSK:   rdv[s] = imsk;
        default: rdv[s] = '0;
      endcase
    end
  end

  assign rd_data   = rd_addr[3] ? rdv[1] : rdv[0];
  assign src_req   = req_w[0];
  assign dst_req   = req_w[1];
  assign src_burst = typ_w[0];
  assign dst_burst = typ_w[1];
  assign src_irq   = irq_w[0];
  assign dst_irq   = irq_w[1];
endmodule

module dma_swreq_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [3:0]     wr_addr,
  input logic [NCH-1:0] src_req,
  input logic [NCH-1:0] src_burst,
  input logic [NCH-1:0] src_ack,
  input logic [NCH-1:0] src_done,
  input logic           src_irq
);
  logic [NCH-1:0] infl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) infl_q <= '0;
    else        infl_q <= (infl_q & ~src_done) | (src_req & src_ack);

  p_ack_drops_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    |(src_req & src_ack) |=> ((src_req & $past(src_req & src_ack)) == '0));

  p_burst_only_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_burst & ~src_req & ~infl_q) == '0);

  p_type_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_burst ^ $past(src_burst)) & infl_q) == '0);

  p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_done & infl_q) && !(wr_en && wr_addr == 4'd0))
      |=> ((src_req & $past(src_done & infl_q)) == '0));

  p_irq_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_irq) |-> $past(|(src_done & infl_q) ||
                             (wr_en && (wr_addr == 4'd3 || wr_addr == 4'd4))));
endmodule

bind dma_swreq_regs dma_swreq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .src_req(src_req), .src_burst(src_burst), .src_ack(src_ack),
  .src_done(src_done), .src_irq(src_irq)
);

// File: tb/tb_dma_swreq_regs.sv
module tb_dma_swreq_regs;
  localparam int NCH = 8;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [NCH-1:0] wr_data = 0, rd_data;
  logic [NCH-1:0] src_req, src_burst, src_ack = 0, src_done = 0;
  logic [NCH-1:0] dst_req, dst_burst, dst_ack = 0, dst_done = 0;
  logic src_irq, dst_irq;
  int total = 0, bad = 0;
  bit over = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_swreq_regs #(.NCH(NCH)) dut (.*);

  // {addr, data, expected readback}
  localparam logic [19:0] VEC [10] = '{
    {4'd0, 8'h01, 8'h01}, {4'd0, 8'h00, 8'h01}, {4'd0, 8'h30, 8'h31},
    {4'd1, 8'h10, 8'h10}, {4'd3, 8'hF0, 8'hF0}, {4'd3, 8'h0F, 8'h0F},
    {4'd4, 8'hAA, 8'hAA}, {4'd8, 8'h02, 8'h02}, {4'd9, 8'h80, 8'h80},
    {4'd0, 8'h00, 8'h31}};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [NCH-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [NCH-1:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic pulse_src(logic [NCH-1:0] a, logic [NCH-1:0] dn);
    @(negedge clk); src_ack = a; src_done = dn;
    @(negedge clk); src_ack = 0; src_done = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_up();
    if (!over) begin
      over = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    logic [NCH-1:0] v;
    do_reset();
    // R8 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v); check("R8 reset readback", v, 0);
    end
    check("R8 reset req", {src_req, dst_req}, 0);
    check("R8 reset irq", {src_irq, dst_irq}, 0);

    // R1 / R10 register vector walk
    foreach (VEC[i]) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd(VEC[i][19:16], v);
      check("R1 R10 register write/readback", v, VEC[i][7:0]);
    end
    rd(4'd8, v); check("R10 dst single untouched by src", v, 8'h02);

    do_reset();
    // R2 / R3 burst first then single on channel 2
    wr(4'd1, 8'h04);
    check("R2 burst alone no request", src_req, 0);
    check("R3 idle burst type", src_burst, 0);
    wr(4'd0, 8'h04);
    check("R2 request raised", src_req, 8'h04);
    check("R3 burst type either order", src_burst, 8'h04);
    pulse_src(8'h04, 0);
    check("R2 request drops after ack", src_req, 0);
    check("R4 burst type held", src_burst, 8'h04);
    pulse_src(0, 8'h04);
    rd(4'd0, v); check("R5 single cleared", v, 0);
    rd(4'd1, v); check("R5 burst cleared", v, 0);
    rd(4'd2, v); check("R6 status set", v, 8'h04);
    check("R7 irq off without enable", src_irq, 0);
    wr(4'd3, 8'h04);
    check("R7 irq enabled", src_irq, 1);
    wr(4'd4, 8'h04);
    check("R7 irq masked", src_irq, 0);
    wr(4'd4, 8'h00);
    check("R7 irq unmasked", src_irq, 1);
    wr(4'd2, 8'h04);
    rd(4'd2, v); check("R6 status W1C", v, 0);
    check("R7 irq low after clear", src_irq, 0);

    // R3 / R4 / R5 single then late burst on channel 0
    wr(4'd0, 8'h01);
    check("R3 single type", {src_req, src_burst}, {8'h01, 8'h00});
    pulse_src(8'h01, 0);
    wr(4'd1, 8'h01);
    check("R4 late burst no type change", src_burst, 0);
    check("R4 no re-request in flight", src_req, 0);
    pulse_src(0, 8'h01);
    rd(4'd1, v); check("R5 late burst dropped", v, 0);
    check("R5 no request after done", src_req, 0);
    check("R7 single completion irq", src_irq, 0);
    wr(4'd3, 8'h01);
    check("R7 shared irq for single", src_irq, 1);
    wr(4'd2, 8'h01);

    // R9 stray done
    pulse_src(0, 8'h80);
    rd(4'd2, v); check("R9 stray done ignored", v, 0);

    // R6 done wins over same-cycle clear on channel 3
    wr(4'd0, 8'h08);
    pulse_src(8'h08, 0);
    @(negedge clk); src_done = 8'h08; wr_en = 1; wr_addr = 4'd2; wr_data = 8'h08;
    @(negedge clk); src_done = 0; wr_en = 0; wr_data = 0;
    rd(4'd2, v); check("R6 done beats clear", v, 8'h08);

    // R10 destination side on channel 1
    wr(4'd8, 8'h02); wr(4'd9, 8'h02);
    check("R10 dst request", {dst_req, dst_burst}, {8'h02, 8'h02});
    check("R10 src unaffected", src_req, 0);
    @(negedge clk); dst_ack = 8'h02;
    @(negedge clk); dst_ack = 0; dst_done = 8'h02;
    @(negedge clk); dst_done = 0;
    rd(4'd10, v); check("R10 dst status", v, 8'h02);
    wr(4'd11, 8'h02);
    check("R10 dst irq", dst_irq, 1);
    rd(4'd2, v); check("R10 src status separate", v, 8'h08);

    finish_up();
  end
endmodule